// File: doc/BRIEF.md
# Multi-Word Vector Compare and Top-Word Scan Engine

This block works on long unsigned integers kept as sequences of 32-bit words in a word-addressed scratch RAM. Each operand is described by two values:

- the RAM address of its lowest word;
- a length counted in words.

A start pulse launches one of two operations, which the block then carries out on its own through a single synchronous read port.

- **Magnitude compare of vector A against vector B.** The engine walks from the top word downward. It stops at the first word pair that differs and reports greater, less or equal as three exclusive flags. When the operands have different lengths, the shorter one is treated as if it were padded with zero words.
- **Scan of vector A.** The engine finds the highest word that is not zero and reports its RAM address. If every word is zero, it raises a zero flag instead. An optional mode also returns the index of the highest set bit inside that word.

Each operation ends with a one-cycle done pulse. At that point the result outputs already hold their new values, and they keep them until a later operation changes them.

The block rejects a request in the cases listed in R2 and R3. A rejected request raises an error flag and starts no walk.

Top module: `vec_cmp_scan`

## Requirements
- R1: Word i of an operand (i counted from 0 at the lowest word) is read at RAM address (base + i) modulo 2048. The RAM returns data one cycle after `mem_rd_en` is asserted.
- R2: A request is rejected in either of these cases: `ptr_a` bit 0 is 1, or a compare is requested (`mode_scan`=0) with `ptr_b` bit 0 equal to 1. A rejected request sets `cfg_err`, leaves every result output unchanged and gives done 0 cycles late (see R10). In scan mode `ptr_b` is ignored. An accepted request clears `cfg_err`.
- R3: A compare requested with `want_top_bit`=1 is rejected in the same way as in R2.
- R4: After a compare, `cmp_flags` holds exactly one set bit, comparing A and B as unsigned numbers: bit 2 means A > B, bit 1 means A < B, bit 0 means A = B. `cmp_flags` resets to 0 and is changed only by accepted compares.
- R5: A compare examines word indices from max(len_a, len_b)-1 downward. A word beyond an operand's length counts as zero. The compare stops at the first index where the two words differ.
- R6: A scan of vector A (length `len_a`) sets `msw_addr` to the RAM address of its highest nonzero word and clears `msw_zero`.
- R7: A scan that finds every word zero sets `msw_zero` to 1 and sets `msw_addr` to `ptr_a`.
- R8: In a scan with `want_top_bit`=1 that finds a nonzero word, `top_bit` receives the index (0 to 31) of the highest 1 in that word. Otherwise `top_bit` keeps its value.
- R9: A length of zero gives A = B for a compare and an all-zero result for a scan (R7), with done 0 cycles late.
- R10: `done` is high for exactly one cycle. Let E be the clock edge that samples `start`, and m the number of word indices examined. `done` is high in the cycle that begins at edge E+3m for a compare and at edge E+2m for a scan. For a rejected or zero-length request it is high in the cycle that begins at edge E.
- R11: `start` and all request inputs are ignored while an operation is in progress. Only one done follows, and it carries the results of the original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| mode_scan | input | 1 | 1 = scan vector A, 0 = compare A with B |
| want_top_bit | input | 1 | Also extract the highest set bit index (scan only) |
| ptr_a | input | 11 | RAM address of the lowest word of A |
| ptr_b | input | 11 | RAM address of the lowest word of B |
| len_a | input | 9 | Length of A in words |
| len_b | input | 9 | Length of B in words |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_addr | output | 11 | RAM read address |
| mem_rdata | input | 32 | RAM read data, valid one cycle after the strobe |
| cmp_flags | output | 3 | Compare result {A>B, A<B, A=B} |
| msw_addr | output | 11 | Address of the highest nonzero word from the last scan |
| msw_zero | output | 1 | Last scan found an all-zero vector |
| top_bit | output | 5 | Highest set bit index in the top word |
| cfg_err | output | 1 | Last request was rejected |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Every result is due at a fixed distance from the edge that samples start:

- 3 cycles per examined word for a compare;
- 2 cycles per examined word for a scan;
- no extra cycles for rejected or zero-length requests.

The bench works out the number of examined words from the data it placed in RAM. It stamps each request with the index of its sampling edge and queues that stamp together with the expected results. The monitor samples on the falling edge. When it sees done, it checks the measured distance against the queued value, which confirms the sequencing and the one-cycle read timing. A done that arrives with nothing queued is reported as a fault.

// File: rtl/vcs_pkg.sv
// Shared types for the vector compare and scan engine.
// Assumes nothing beyond the sequencing states it names.
package vcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_DONE
    } vcs_state_e;

    localparam int FLAG_GT = 2;
    localparam int FLAG_LT = 1;
    localparam int FLAG_EQ = 0;
endpackage

// File: rtl/vcs_addr_gen.sv
// Forms the RAM address of one operand word from a base address and a word
// index. Assumes the RAM address space wraps at its natural width.
module vcs_addr_gen #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 9
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    // Modular base-plus-index sum.
    always_comb begin
        addr = base + ADDR_W'(idx);
    end
endmodule

// File: rtl/vcs_word_eval.sv
// Compares one word pair as unsigned values. Also reports whether the first
// word is nonzero and where its highest set bit is. Purely combinational.
module vcs_word_eval #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] a_word,
    input  logic [DATA_W-1:0] b_word,
    output logic              a_gt,
    output logic              a_lt,
    output logic              a_nz,
    output logic [IDX_W-1:0]  a_msb
);
    // Magnitude relation of the pair.
    always_comb begin
        a_gt = a_word > b_word;
        a_lt = a_word < b_word;
        a_nz = |a_word;
    end

    // Priority search: the last set bit seen while counting upward wins.
    always_comb begin
        a_msb = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (a_word[k]) a_msb = IDX_W'(k);
        end
    end
endmodule

// File: rtl/vec_cmp_scan.sv
// Top of the vector compare and scan engine.
// It walks multi-word operands from the top word downward through one
// synchronous read port with a read latency of one cycle.
// Assumptions:
//   - the request inputs matter only in the cycle where start is sampled
//     while idle;
//   - the RAM holds mem_rdata when no read is issued, but the engine never
//     relies on that.
module vec_cmp_scan #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_scan,
    input  logic              want_top_bit,
    input  logic [ADDR_W-1:0] ptr_a,
    input  logic [ADDR_W-1:0] ptr_b,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [LEN_W-1:0]  len_b,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [2:0]        cmp_flags,
    output logic [ADDR_W-1:0] msw_addr,
    output logic              msw_zero,
    output logic [$clog2(DATA_W)-1:0] top_bit,
    output logic              cfg_err,
    output logic              done
);
    import vcs_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    vcs_state_e        state;
    logic              phase_b;
    logic [LEN_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] pa_q, pb_q;
    logic [LEN_W-1:0]  la_q, lb_q;
    logic              scan_q, want_q;
    logic [DATA_W-1:0] a_word_q;

    logic              a_ok, b_ok, req_bad;
    logic [LEN_W-1:0]  req_len;
    logic [ADDR_W-1:0] cur_base;
    logic [DATA_W-1:0] eval_a, eval_b;
    logic              w_gt, w_lt, w_nz;
    logic [IDX_W-1:0]  w_msb;

    // Decode of the request and of the current word index against the lengths.
    always_comb begin
        a_ok     = cur_idx < la_q;
        b_ok     = cur_idx < lb_q;
        req_bad  = ptr_a[0] | (~mode_scan & (ptr_b[0] | want_top_bit));
        req_len  = mode_scan ? len_a : ((len_a > len_b) ? len_a : len_b);
        cur_base = (state == ST_FETCH && phase_b) ? pb_q : pa_q;
    end

    vcs_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .base (cur_base),
        .idx  (cur_idx),
        .addr (mem_addr)
    );

    // Read strobe: only during fetch, and only for words inside the operand.
    always_comb begin
        mem_rd_en = (state == ST_FETCH) && (phase_b ? b_ok : a_ok);
    end

    // Operand selection for the evaluation cycle; absent words count as zero.
    always_comb begin
        eval_a = scan_q ? mem_rdata : a_word_q;
        eval_b = b_ok ? mem_rdata : '0;
    end

    vcs_word_eval #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_eval (
        .a_word (eval_a),
        .b_word (eval_b),
        .a_gt   (w_gt),
        .a_lt   (w_lt),
        .a_nz   (w_nz),
        .a_msb  (w_msb)
    );

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase_b   <= 1'b0;
            cur_idx   <= '0;
            pa_q      <= '0;
            pb_q      <= '0;
            la_q      <= '0;
            lb_q      <= '0;
            scan_q    <= 1'b0;
            want_q    <= 1'b0;
            a_word_q  <= '0;
            cmp_flags <= '0;
            msw_addr  <= '0;
            msw_zero  <= 1'b0;
            top_bit   <= '0;
            cfg_err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (req_bad) begin
                            cfg_err <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            cfg_err <= 1'b0;
                            pa_q    <= ptr_a;
                            pb_q    <= ptr_b;
                            la_q    <= len_a;
                            lb_q    <= len_b;
                            scan_q  <= mode_scan;
                            want_q  <= want_top_bit;
                            phase_b <= 1'b0;
                            if (req_len == '0) begin
                                state <= ST_DONE;
                                if (mode_scan) begin
                                    msw_zero <= 1'b1;
                                    msw_addr <= ptr_a;
                                end else begin
                                    cmp_flags <= 3'b001;
                                end
                            end else begin
                                cur_idx <= req_len - LEN_W'(1);
                                state   <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_FETCH: begin
                    if (!scan_q && !phase_b) begin
                        phase_b <= 1'b1;
                    end else begin
                        phase_b <= 1'b0;
                        state   <= ST_EVAL;
                        if (!scan_q) a_word_q <= a_ok ? mem_rdata : '0;
                    end
                end
                ST_EVAL: begin
                    if (scan_q) begin
                        if (w_nz) begin
                            msw_addr <= mem_addr;
                            msw_zero <= 1'b0;
                            if (want_q) top_bit <= w_msb;
                            state <= ST_DONE;
                        end else if (cur_idx == '0) begin
                            msw_addr <= pa_q;
                            msw_zero <= 1'b1;
                            state    <= ST_DONE;
                        end else begin
                            cur_idx <= cur_idx - LEN_W'(1);
                            state   <= ST_FETCH;
                        end
                    end else begin
                        if (w_gt) begin
                            cmp_flags <= 3'b100;
                            state     <= ST_DONE;
                        end else if (w_lt) begin
                            cmp_flags <= 3'b010;
                            state     <= ST_DONE;
                        end else if (cur_idx == '0) begin
                            cmp_flags <= 3'b001;
                            state     <= ST_DONE;
                        end else begin
                            cur_idx <= cur_idx - LEN_W'(1);
                            state   <= ST_FETCH;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion strobe.
    always_comb begin
        done = (state == ST_DONE);
    end

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_flags));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_reject_keeps_results_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(cmp_flags) && $stable(msw_addr)
                            && $stable(msw_zero) && $stable(top_bit)));

    assert_busy_holds_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH || state == ST_EVAL) |=>
            ($stable(pa_q) && $stable(pb_q) && $stable(la_q) && $stable(lb_q) && $stable(scan_q)));

    assert_read_only_in_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (state == ST_FETCH));
endmodule

// File: tb/test_vec_cmp_scan.sv
// Scoreboard bench: request tasks queue expected results; a monitor checks them on done.
module test_vec_cmp_scan;
    logic        clk = 1'b0;
    logic        rst_n, start, mode_scan, want_top_bit;
    logic [10:0] ptr_a, ptr_b;
    logic [8:0]  len_a, len_b;
    logic        mem_rd_en;
    logic [10:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [2:0]  cmp_flags;
    logic [10:0] msw_addr;
    logic        msw_zero;
    logic [4:0]  top_bit;
    logic        cfg_err, done;

    always #4 clk = ~clk;

    vec_cmp_scan i_vec_cmp_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_scan(mode_scan),
        .want_top_bit(want_top_bit), .ptr_a(ptr_a), .ptr_b(ptr_b),
        .len_a(len_a), .len_b(len_b), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .cmp_flags(cmp_flags), .msw_addr(msw_addr),
        .msw_zero(msw_zero), .top_bit(top_bit), .cfg_err(cfg_err), .done(done)
    );

    logic [31:0] ram [0:2047];
    always @(posedge clk) if (mem_rd_en) mem_rdata <= ram[mem_addr];

    typedef struct {
        logic [2:0]  flags;
        logic [10:0] maddr;
        logic        mz;
        logic [4:0]  tb;
        logic        err;
        int          lat;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0, cyc = 0, t0 = 0;
    logic [2:0]  m_flags = '0;
    logic [10:0] m_maddr = '0;
    logic        m_mz = 1'b0, m_err = 1'b0;
    logic [4:0]  m_tb = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops one expected item for each done pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    check("R11 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " R4 flags"}, 32'(cmp_flags), 32'(e.flags));
                    check({e.tag, " R6 msw_addr"}, 32'(msw_addr), 32'(e.maddr));
                    check({e.tag, " R7 msw_zero"}, 32'(msw_zero), 32'(e.mz));
                    check({e.tag, " R8 top_bit"}, 32'(top_bit), 32'(e.tb));
                    check({e.tag, " R2 cfg_err"}, 32'(cfg_err), 32'(e.err));
                    check({e.tag, " R10 latency"}, 32'(cyc - t0), 32'(e.lat));
                end
            end
        end
    end

    task automatic go(bit scan, bit want, logic [10:0] pa, logic [10:0] pb,
                      logic [8:0] la, logic [8:0] lb, int lat, string tag);
        exp_t e;
        e.flags = m_flags; e.maddr = m_maddr; e.mz = m_mz; e.tb = m_tb;
        e.err = m_err; e.lat = lat; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        mode_scan = scan; want_top_bit = want; ptr_a = pa; ptr_b = pb;
        len_a = la; len_b = lb; start = 1'b1; t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Compare: m words examined gives 3m cycles (R5, R10).
    task automatic do_cmp(logic [10:0] pa, logic [10:0] pb, logic [8:0] la, logic [8:0] lb,
                          logic [2:0] f, int m, string tag);
        m_flags = f; m_err = 1'b0;
        go(1'b0, 1'b0, pa, pb, la, lb, 3 * m, tag);
    endtask

    // Scan: m words examined gives 2m cycles (R6, R7, R8).
    task automatic do_scan(logic [10:0] pa, logic [10:0] pb, logic [8:0] la, bit want,
                           logic [10:0] ea, bit ez, logic [4:0] etb, int m, string tag);
        m_maddr = ea; m_mz = ez; m_err = 1'b0;
        if (want && !ez) m_tb = etb;
        go(1'b1, want, pa, pb, la, 9'd0, 2 * m, tag);
    endtask

    task automatic do_bad(bit scan, bit want, logic [10:0] pa, logic [10:0] pb, string tag);
        m_err = 1'b1;
        go(scan, want, pa, pb, 9'd2, 9'd2, 0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        summary();
    end

    initial begin
        for (int i = 0; i < 2048; i++) ram[i] = '0;
        rst_n = 1'b0; start = 1'b0; mode_scan = 1'b0; want_top_bit = 1'b0;
        ptr_a = '0; ptr_b = '0; len_a = '0; len_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset flags", 32'(cmp_flags), 32'd0);
        check("R6 reset msw_addr", 32'(msw_addr), 32'd0);
        check("R7 reset msw_zero", 32'(msw_zero), 32'd0);
        check("R8 reset top_bit", 32'(top_bit), 32'd0);
        check("R2 reset cfg_err", 32'(cfg_err), 32'd0);
        check("R10 reset done", 32'(done), 32'd0);

        // R4 R5: equal operands, all three words examined
        ram[16] = 1; ram[17] = 2; ram[18] = 3;
        ram[64] = 1; ram[65] = 2; ram[66] = 3;
        do_cmp(11'd16, 11'd64, 9'd3, 9'd3, 3'b001, 3, "R5 equal");
        ram[18] = 5;
        do_cmp(11'd16, 11'd64, 9'd3, 9'd3, 3'b100, 1, "R5 top differs");
        ram[18] = 3; ram[19] = 9; ram[67] = 9; ram[17] = 1;
        do_cmp(11'd16, 11'd64, 9'd4, 9'd4, 3'b010, 3, "R5 middle differs");
        // R5 zero extension of the shorter operand
        ram[66] = 0; ram[17] = 7;
        do_cmp(11'd16, 11'd64, 9'd2, 9'd3, 3'b100, 2, "R5 short A padded");
        ram[66] = 1;
        do_cmp(11'd16, 11'd64, 9'd2, 9'd3, 3'b010, 1, "R5 B longer nonzero");
        do_cmp(11'd16, 11'd64, 9'd3, 9'd1, 3'b100, 1, "R5 A longer");
        // R4 unsigned magnitude
        ram[16] = 32'h8000_0000; ram[64] = 32'h7fff_ffff;
        do_cmp(11'd16, 11'd64, 9'd1, 9'd1, 3'b100, 1, "R4 unsigned");

        // R11: a second request during the walk is ignored
        m_flags = 3'b100; m_err = 1'b0;
        begin
            exp_t e;
            e.flags = m_flags; e.maddr = m_maddr; e.mz = m_mz; e.tb = m_tb;
            e.err = 1'b0; e.lat = 3; e.tag = "R11 busy";
            q.push_back(e);
        end
        @(negedge clk);
        mode_scan = 1'b0; want_top_bit = 1'b0; ptr_a = 11'd16; ptr_b = 11'd64;
        len_a = 9'd1; len_b = 9'd1; start = 1'b1; t0 = cyc + 1;
        @(negedge clk);
        mode_scan = 1'b1; ptr_a = 11'd129; len_a = 9'd5;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);

        // R6 R8 scans
        ram[128] = 32'hF; ram[129] = 32'h0001_0000; ram[130] = 0; ram[131] = 0;
        do_scan(11'd128, 11'd0, 9'd4, 1'b1, 11'd129, 1'b0, 5'd16, 3, "R8 bit16");
        ram[131] = 32'h100;
        do_scan(11'd128, 11'd0, 9'd4, 1'b0, 11'd131, 1'b0, 5'd0, 1, "R8 mode off keeps");
        ram[131] = 32'h8000_0001;
        do_scan(11'd128, 11'd0, 9'd4, 1'b1, 11'd131, 1'b0, 5'd31, 1, "R8 bit31");
        ram[131] = 0; ram[129] = 0; ram[128] = 1;
        do_scan(11'd128, 11'd0, 9'd4, 1'b1, 11'd128, 1'b0, 5'd0, 4, "R6 lowest word");
        ram[128] = 0;
        ram[1] = 0; ram[0] = 32'h2;
        do_scan(11'd2046, 11'd0, 9'd4, 1'b1, 11'd0, 1'b0, 5'd1, 2, "R1 wrap");
        do_scan(11'd128, 11'd0, 9'd4, 1'b1, 11'd128, 1'b1, 5'd0, 4, "R7 all zero");

        // R9 zero lengths
        do_cmp(11'd16, 11'd64, 9'd0, 9'd0, 3'b001, 0, "R9 compare len0");
        do_scan(11'd40, 11'd0, 9'd0, 1'b0, 11'd40, 1'b1, 5'd0, 0, "R9 scan len0");

        // R2 R3 rejections, then recovery
        do_bad(1'b1, 1'b0, 11'd129, 11'd0, "R2 odd ptr_a");
        do_bad(1'b0, 1'b0, 11'd16, 11'd65, "R2 odd ptr_b");
        do_bad(1'b0, 1'b1, 11'd16, 11'd64, "R3 top bit with compare");
        ram[130] = 32'h40;
        do_scan(11'd128, 11'd77, 9'd4, 1'b0, 11'd130, 1'b0, 5'd0, 2, "R2 scan ignores ptr_b");

        summary();
    end
endmodule